// File: doc/BRIEF.md
# Run-time width packet link serializer with loopback deserializer

This block carries packets built from 32-bit words across a link whose lane count is picked at run time, from 2 up to 32 lanes. Each word is cut into bit times of the chosen width and sent least-significant slice first. The link moves data on both clock edges, so every clock cycle carries two bit-time slots on a 64-bit beat bus. The first word of a packet is the command word. When the sender flags an extension, an extra control word goes before the command word. An address, when present, is the word after the command word. Payload words follow, and the final word is zero-padded past its last valid byte.

On the transmit side, words enter through a valid/ready interface that carries start and end markers. The link side drives the beat bus, a per-slot valid and control flag, packet start and end markers, and the width code in use. A deserializer in the same module takes the same link signals on its own inputs and rebuilds the words. Wiring the link outputs to these inputs gives a loopback. The deserializer also flags a packet that ends partway through a word.

Top module: `wlink_serdes`

## Requirements
- R1: Width code `in_wsel` maps 0→2, 1→4, 2→8, 3→16 and 4 to 7→32 lanes, giving 32/W bit times per word. Slot 0 is `lnk_data[31:0]` and comes first. Slot 1 is `lnk_data[63:32]`. In each slot only lanes below W carry data and the rest are zero. At 32 lanes `lnk_vld` is 01; otherwise it is 11 while a word is on the link.
- R2: The bit time with index k carries word bits [k·W+W-1 : k·W]. Bit time 0 is in slot 0 of the word's first cycle.
- R3: Words go out with no idle cycle between them. A packet of N words takes exactly N·16/W cycles at W ≤ 16, or N cycles at W = 32. `in_ready` stays low until the last cycle of the current word.
- R4: `lnk_ctl` is high in valid slots of the command word, and of the extension word when `in_ext` is set with the first word. It is low for every later word.
- R5: `lnk_sop` is high on the first cycle of a packet. `lnk_eop` is high on its last cycle.
- R6: On the end word, `in_lastb` = 1, 2 or 3 keeps that many low bytes and sends the other bytes as zero. A value of 0 keeps all four bytes.
- R7: The width is taken from `in_wsel` only with the first word of a packet. Later changes have no effect until the next packet. `lnk_wsel` shows the code in use.
- R8: The deserializer rebuilds each word with its control, start and end flags. It pulses `rx_word_valid` in the cycle after the last beat of the word.
- R9: If `rx_eop` arrives while a word is incomplete, `rx_err` pulses in the next cycle and no word is produced. The partial bits are dropped, so the next word comes out clean.
- R10: After reset, `lnk_vld` is 0, `in_ready` is 1, and `rx_word_valid` and `rx_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Word taken this cycle |
| in_data | input | 32 | Word |
| in_sop | input | 1 | First word of packet |
| in_eop | input | 1 | Last word of packet |
| in_ext | input | 1 | First word is an extension control word |
| in_lastb | input | 2 | Valid bytes in last word, 0 = four |
| in_wsel | input | 3 | Lane width code |
| lnk_data | output | 64 | Two bit-time slots |
| lnk_vld | output | 2 | Slot valid |
| lnk_ctl | output | 2 | Slot carries a control word |
| lnk_sop | output | 1 | First cycle of packet |
| lnk_eop | output | 1 | Last cycle of packet |
| lnk_wsel | output | 3 | Width code in use |
| rx_data | input | 64 | Received slots |
| rx_vld | input | 2 | Received slot valid |
| rx_ctl | input | 2 | Received control flag |
| rx_sop | input | 1 | Received packet start |
| rx_eop | input | 1 | Received packet end |
| rx_wsel | input | 3 | Received width code |
| rx_word_valid | output | 1 | Rebuilt word valid |
| rx_word | output | 32 | Rebuilt word |
| rx_word_ctl | output | 1 | Rebuilt word is a control word |
| rx_word_sop | output | 1 | Rebuilt word starts packet |
| rx_word_eop | output | 1 | Rebuilt word ends packet |
| rx_err | output | 1 | Packet ended inside a word |

## Verification
The block has no parameters, so the bench uses its single build and sweeps all eight width codes at run time. This reaches both slot layouts: 32 lanes with one slot, and 2 to 16 lanes with both slots. It also reaches the longest case, eight cycles per word at two lanes. Packets with and without the extension word and every end-byte count are looped back. Width codes that change partway through a packet test that the width is held for the whole packet. Injected truncated frames on the receive inputs exercise the error path and recovery.

// File: rtl/wlink_serdes.sv
module wlink_serdes (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  input  logic        in_sop,
  input  logic        in_eop,
  input  logic        in_ext,
  input  logic [1:0]  in_lastb,
  input  logic [2:0]  in_wsel,
  output logic [63:0] lnk_data,
  output logic [1:0]  lnk_vld,
  output logic [1:0]  lnk_ctl,
  output logic        lnk_sop,
  output logic        lnk_eop,
  output logic [2:0]  lnk_wsel,
  input  logic [63:0] rx_data,
  input  logic [1:0]  rx_vld,
  input  logic [1:0]  rx_ctl,
  input  logic        rx_sop,
  input  logic        rx_eop,
  input  logic [2:0]  rx_wsel,
  output logic        rx_word_valid,
  output logic [31:0] rx_word,
  output logic        rx_word_ctl,
  output logic        rx_word_sop,
  output logic        rx_word_eop,
  output logic        rx_err
);

  function automatic logic [5:0] lanes(input logic [2:0] s);
    case (s)
      3'd0:    return 6'd2;
      3'd1:    return 6'd4;
      3'd2:    return 6'd8;
      3'd3:    return 6'd16;
      default: return 6'd32;
    endcase
  endfunction

  function automatic logic [3:0] cyc_per_word(input logic [2:0] s);
    case (s)
      3'd0:    return 4'd8;
      3'd1:    return 4'd4;
      3'd2:    return 4'd2;
      default: return 4'd1;
    endcase
  endfunction

  function automatic logic [31:0] lmask(input logic [5:0] w);
    return (w >= 6'd32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
  endfunction

  // transmit side
  logic        active, ctl_r, sop_r, weop, cmd_next;
  logic [3:0]  rem;
  logic [31:0] sh, slot0, slot1, keep, dn, mn, mc;
  logic [1:0]  vld;
  logic [2:0]  wsel_r, wsel_n;
  logic [5:0]  wn, wc;
  logic        accept;

  assign in_ready = !active || (rem == 4'd1);
  assign accept   = in_valid && in_ready;
  assign wsel_n   = in_sop ? in_wsel : wsel_r;
  assign wn       = lanes(wsel_n);
  assign wc       = lanes(wsel_r);
  assign mn       = lmask(wn);
  assign mc       = lmask(wc);
  assign keep     = (in_eop && in_lastb != 2'd0) ? ((32'd1 << {in_lastb, 3'b000}) - 32'd1) : 32'hFFFF_FFFF;
  assign dn       = in_data & keep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; rem <= '0; sh <= '0; slot0 <= '0; slot1 <= '0; vld <= '0;
      ctl_r <= 1'b0; sop_r <= 1'b0; weop <= 1'b0; cmd_next <= 1'b0; wsel_r <= 3'd4;
    end else if (accept) begin
      active   <= 1'b1;
      wsel_r   <= wsel_n;
      rem      <= cyc_per_word(wsel_n);
      ctl_r    <= in_sop || cmd_next;
      cmd_next <= in_sop && in_ext;
      sop_r    <= in_sop;
      weop     <= in_eop;
      if (wn == 6'd32) begin
        slot0 <= dn; slot1 <= '0; sh <= '0; vld <= 2'b01;
      end else begin
        slot0 <= dn & mn;
        slot1 <= (dn >> wn) & mn;
        sh    <= dn >> (2 * wn);
        vld   <= 2'b11;
      end
    end else if (active && rem > 4'd1) begin
      slot0 <= sh & mc;
      slot1 <= (sh >> wc) & mc;
      sh    <= sh >> (2 * wc);
      rem   <= rem - 4'd1;
      sop_r <= 1'b0;
    end else if (active) begin
      active <= 1'b0; vld <= '0; sop_r <= 1'b0; rem <= '0;
    end
  end

  assign lnk_data = {slot1, slot0};
  assign lnk_vld  = vld;
  assign lnk_ctl  = vld & {2{ctl_r}};
  assign lnk_sop  = sop_r;
  assign lnk_eop  = active && weop && (rem == 4'd1);
  assign lnk_wsel = wsel_r;

  assert_slot_shape_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_vld != 2'b10);
  assert_single_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (lnk_vld != 2'b00) |-> ((lnk_vld == 2'b01) == (lanes(lnk_wsel) == 6'd32)));
  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (lnk_vld == 2'b11) |-> (((lnk_data[31:0] | lnk_data[63:32]) & ~lmask(lanes(lnk_wsel))) == 32'd0));
  assert_no_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> (lnk_vld != 2'b00));
  assert_sop_mark_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_sop) |=> lnk_sop);
  assert_width_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lnk_vld != 2'b00 && !lnk_sop && $past(lnk_vld != 2'b00)) |-> (lnk_wsel == $past(lnk_wsel)));

  // receive side
  logic [31:0] acc, rm, b0, b1, merged;
  logic [6:0]  pos, n0, n1, ntot, p1;
  logic [5:0]  rw;
  logic        psop, done, sopn;

  assign rw     = lanes(rx_wsel);
  assign rm     = lmask(rw);
  assign b0     = rx_data[31:0] & rm;
  assign b1     = rx_data[63:32] & rm;
  assign n0     = rx_vld[0] ? {1'b0, rw} : 7'd0;
  assign n1     = rx_vld[1] ? {1'b0, rw} : 7'd0;
  assign ntot   = n0 + n1;
  assign p1     = pos + n0;
  assign merged = acc | (rx_vld[0] ? (b0 << pos) : 32'd0) | (rx_vld[1] ? (b1 << p1) : 32'd0);
  assign done   = (rx_vld != 2'b00) && ((pos + ntot) >= 7'd32);
  assign sopn   = psop || rx_sop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0; pos <= '0; psop <= 1'b0; rx_word_valid <= 1'b0; rx_word <= '0;
      rx_word_ctl <= 1'b0; rx_word_sop <= 1'b0; rx_word_eop <= 1'b0; rx_err <= 1'b0;
    end else begin
      rx_word_valid <= 1'b0;
      rx_err        <= 1'b0;
      if (rx_vld != 2'b00) begin
        if (done) begin
          rx_word_valid <= 1'b1;
          rx_word       <= merged;
          rx_word_ctl   <= rx_ctl[0];
          rx_word_sop   <= sopn;
          rx_word_eop   <= rx_eop;
          acc <= '0; pos <= '0; psop <= 1'b0;
        end else if (rx_eop) begin
          rx_err <= 1'b1;
          acc <= '0; pos <= '0; psop <= 1'b0;
        end else begin
          acc <= merged; pos <= pos + ntot; psop <= sopn;
        end
      end
    end
  end

  assert_err_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |-> !rx_word_valid);

endmodule

// File: tb/wlink_serdes_bench.sv
module wlink_serdes_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        in_valid = 0, in_sop = 0, in_eop = 0, in_ext = 0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic [1:0]  in_lastb = '0;
  logic [2:0]  in_wsel = '0;
  logic [63:0] lnk_data;
  logic [1:0]  lnk_vld, lnk_ctl;
  logic        lnk_sop, lnk_eop;
  logic [2:0]  lnk_wsel;
  logic        inj = 0, inj_sop = 0, inj_eop = 0;
  logic [63:0] inj_data = '0;
  logic [1:0]  inj_vld = '0;
  logic [2:0]  inj_wsel = '0;
  logic        rx_word_valid, rx_word_ctl, rx_word_sop, rx_word_eop, rx_err;
  logic [31:0] rx_word;

  wlink_serdes u_wlink_serdes (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_sop(in_sop),
    .in_eop(in_eop), .in_ext(in_ext), .in_lastb(in_lastb), .in_wsel(in_wsel),
    .lnk_data(lnk_data), .lnk_vld(lnk_vld), .lnk_ctl(lnk_ctl), .lnk_sop(lnk_sop),
    .lnk_eop(lnk_eop), .lnk_wsel(lnk_wsel),
    .rx_data(inj ? inj_data : lnk_data), .rx_vld(inj ? inj_vld : lnk_vld),
    .rx_ctl(inj ? 2'b00 : lnk_ctl), .rx_sop(inj ? inj_sop : lnk_sop),
    .rx_eop(inj ? inj_eop : lnk_eop), .rx_wsel(inj ? inj_wsel : lnk_wsel),
    .rx_word_valid(rx_word_valid), .rx_word(rx_word), .rx_word_ctl(rx_word_ctl),
    .rx_word_sop(rx_word_sop), .rx_word_eop(rx_word_eop), .rx_err(rx_err));

  int checks = 0, fails = 0, cyc = 0, sop_cyc = 0;
  logic [34:0] expq[$];
  logic [31:0] firstq[$];
  int durq[$];
  int wselq[$];
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int f_lanes(input int s);
    return (s < 4) ? (2 << s) : 32;
  endfunction
  function automatic int f_cyc(input int s);
    return (f_lanes(s) == 32) ? 1 : 16 / f_lanes(s);
  endfunction
  function automatic logic [31:0] f_mask(input int w);
    return (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
  endfunction
  function automatic logic [31:0] f_pad(input logic [31:0] w, input bit last, input int lb);
    return (last && lb != 0) ? (w & ((32'd1 << (8 * lb)) - 32'd1)) : w;
  endfunction

  task automatic send_pkt(input int ws, input bit ext, input int nw, input int lb, input bit chg);
    durq.push_back(nw * f_cyc(ws));
    wselq.push_back(ws);
    for (int i = 0; i < nw; i++) begin
      logic [31:0] w;
      @(negedge clk);
      w = $urandom;
      in_valid = 1; in_data = w; in_sop = (i == 0); in_eop = (i == nw - 1);
      in_ext = ext; in_lastb = 2'(lb);
      in_wsel = (i == 0 || !chg) ? 3'(ws) : 3'($urandom % 8);
      expq.push_back({(i == 0) || (ext && i == 1), i == 0, i == nw - 1, f_pad(w, i == nw - 1, lb)});
      if (i == 0) firstq.push_back(f_pad(w, nw == 1, lb));
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 0; in_sop = 0; in_eop = 0;
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    cyc++;
    if (lnk_vld != 2'b00 && lnk_sop) begin
      logic [31:0] fw, m;
      int w;
      sop_cyc = cyc;
      w = f_lanes(int'(lnk_wsel));
      m = f_mask(w);
      fw = (firstq.size() > 0) ? firstq.pop_front() : 32'hDEAD_BEEF;
      chk(lnk_data[31:0] == (fw & m), "R2 first bit time in slot0", lnk_data[31:0], fw & m);
      if (w < 32) chk(lnk_data[63:32] == ((fw >> w) & m), "R2 second bit time in slot1", lnk_data[63:32], (fw >> w) & m);
      chk(lnk_vld == ((w == 32) ? 2'b01 : 2'b11), "R1 slot valid pattern", lnk_vld, (w == 32) ? 2'b01 : 2'b11);
      chk(lnk_ctl == lnk_vld, "R4 control flag on first word", lnk_ctl, lnk_vld);
    end
    if (lnk_vld != 2'b00 && lnk_eop) begin
      int ed, ew;
      ed = (durq.size() > 0) ? durq.pop_front() : -1;
      ew = (wselq.size() > 0) ? wselq.pop_front() : -1;
      chk(cyc - sop_cyc + 1 == ed, "R3 R5 packet length in cycles", cyc - sop_cyc + 1, ed);
      chk(int'(lnk_wsel) == ew, "R7 width held for packet", lnk_wsel, ew);
    end
    if (rx_word_valid && !inj) begin
      logic [34:0] e;
      e = (expq.size() > 0) ? expq.pop_front() : 35'h7_FFFF_FFFF;
      chk(rx_word == e[31:0], "R8 R6 rebuilt word", rx_word, e[31:0]);
      chk({rx_word_ctl, rx_word_sop, rx_word_eop} == e[34:32], "R4 R8 word flags",
          {rx_word_ctl, rx_word_sop, rx_word_eop}, e[34:32]);
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1;
      chk(0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(lnk_vld == 2'b00, "R10 reset link idle", lnk_vld, 0);
    chk(in_ready == 1'b1, "R10 reset ready", in_ready, 1);
    chk(rx_word_valid == 1'b0 && rx_err == 1'b0, "R10 reset receive idle", {rx_word_valid, rx_err}, 0);
    rst_n = 1;
    void'($urandom(32'd1234));
    send_pkt(0, 1, 3, 1, 0);
    send_pkt(4, 0, 4, 0, 0);
    send_pkt(7, 1, 1, 2, 0);
    send_pkt(1, 0, 2, 3, 1);
    send_pkt(3, 1, 5, 0, 1);
    send_pkt(2, 0, 1, 1, 1);
    send_pkt(5, 0, 3, 2, 1);
    send_pkt(0, 0, 4, 3, 1);
    for (int p = 0; p < 40; p++) begin
      send_pkt($urandom % 8, $urandom % 2, 1 + $urandom % 8, $urandom % 4, $urandom % 2);
      repeat ($urandom % 3) @(negedge clk);
    end
    repeat (30) @(negedge clk);
    chk(expq.size() == 0, "R8 all words rebuilt", expq.size(), 0);
    chk(durq.size() == 0, "R5 all packets ended", durq.size(), 0);
    inj = 1;
    @(negedge clk);
    inj_wsel = 0; inj_vld = 2'b11; inj_sop = 1; inj_eop = 1; inj_data = 64'h3_0000_0002;
    @(negedge clk);
    inj_vld = 2'b00; inj_sop = 0; inj_eop = 0;
    chk(rx_err == 1'b1, "R9 error on short word", rx_err, 1);
    chk(rx_word_valid == 1'b0, "R9 no word on error", rx_word_valid, 0);
    inj_wsel = 4; inj_vld = 2'b01; inj_sop = 1; inj_eop = 1; inj_data = 64'h0000_0000_A5C3_0F18;
    @(negedge clk);
    inj_vld = 2'b00; inj_sop = 0; inj_eop = 0;
    chk(rx_word_valid == 1'b1 && rx_word == 32'hA5C3_0F18, "R9 clean word after error", rx_word, 32'hA5C3_0F18);
    chk(rx_err == 1'b0, "R9 no error on full word", rx_err, 0);
    inj_wsel = 1; inj_vld = 2'b11; inj_sop = 1; inj_eop = 0; inj_data = 64'h0000_000F_0000_0005;
    @(negedge clk);
    inj_eop = 1; inj_sop = 0; inj_data = 64'h0000_0003_0000_0009;
    @(negedge clk);
    inj_vld = 2'b00; inj_eop = 0;
    chk(rx_err == 1'b1, "R9 error after partial cycles", rx_err, 1);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule